// File: doc/BRIEF.md
# Delay Setting Load Interface

This block owns the 8-bit value that selects the tap of a programmable delay element. The value can be loaded in one of two ways, chosen by a mode input. In parallel mode, a level-sensitive latch passes eight data inputs through to the setting while the load enable is high and holds the setting while it is low. In serial mode, a three-wire shift interface is used. A high load enable arms a shift register. Each rising edge of the serial clock shifts one bit in, most significant bit first. The shifted word becomes the setting when the load enable falls, provided at least eight bits were shifted.

The serial output always shows the bit that is about to leave the shift register. At arming, the register holds the active setting, so the first bit out is the old bit 7 and each clock exposes the next older bit. Software can therefore read the setting without destroying it by writing each bit back as it reads it. Several blocks can also be chained output-to-input, with eight bits shifted per block on every transfer.

All pin-level inputs are resynchronised into the system clock domain before use. A one-cycle strobe marks every change of the active setting.

Top module: `dly_setting_loader`

## Requirements
- R1: `ser_mode` = 0 selects parallel loading and `ser_mode` = 1 selects serial loading; in serial mode `par_data` has no effect on `setting`.
- R2: In parallel mode with `load_en` high, `setting` equals `par_data` three clock cycles after `par_data` changes (two synchroniser stages plus the setting register); with `load_en` held high from reset, the setting follows the inputs from the first cycles after reset.
- R3: In parallel mode with `load_en` low, `setting` holds its value whatever `par_data` does.
- R4: In serial mode with `load_en` high, each rising edge of `ser_clk` shifts `ser_din` into bit 0 of the shift register and moves every bit one place toward bit 7, so the word is sent MSB first; `ser_clk` edges while `load_en` is low shift nothing.
- R5: The shifted word becomes `setting` three cycles after the falling edge of `load_en`, and only if at least 8 rising `ser_clk` edges occurred while armed; with fewer, `setting` is unchanged; while armed, `setting` never changes.
- R6: `ser_dout` equals bit 7 of the shift register, which holds the active setting whenever the interface is not armed; feeding `ser_dout` back into `ser_din` for 8 edges leaves `setting` unchanged.
- R7: When more than 8 bits are shifted, the last 8 bits sent form the new setting, and the earlier bits appear on `ser_dout`, MSB first, during shifts 9 onward, as a next device in a chain would receive them.
- R8: `setting_upd` is high for exactly one cycle in the same cycle in which `setting` takes a new value, in either mode, and stays low when a load leaves the value the same.
- R9: A synchronous active-high `rst` clears `setting`, the shift register (so `ser_dout` = 0) and `setting_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | Load mode: 0 parallel, 1 serial |
| load_en | input | 1 | Latch enable (parallel) or shift arm (serial) |
| par_data | input | 8 | Parallel setting inputs |
| ser_clk | input | 1 | Serial shift clock, sampled in the `clk` domain |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output for read-back and chaining |
| setting | output | 8 | Active delay setting |
| setting_upd | output | 1 | One-cycle strobe on every change of `setting` |

## Verification
Every pin input passes two synchroniser flops. A parallel change therefore reaches `setting` on the third rising clock edge after it is driven. A `ser_clk` rise updates `ser_dout` on the third edge, and a `load_en` fall commits the shifted word and raises `setting_upd` on the third edge. The bench drives inputs on falling edges. A behavioural model, built from a queue that delays the sampled inputs by the synchroniser depth, is compared with `setting`, `setting_upd` and `ser_dout` at every falling edge. The directed checks wait at least those three edges before sampling the committed value, and they capture `ser_dout` just before each serial clock rise.

// File: rtl/dly_setting_pkg.sv
package dly_setting_pkg;
  typedef enum logic {
    LOAD_PARALLEL = 1'b0,
    LOAD_SERIAL   = 1'b1
  } load_mode_e;
endpackage

// File: rtl/dly_input_sync.sv
module dly_input_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/dly_serial_shifter.sv
module dly_serial_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             shift_pulse,
  input  logic             din,
  input  logic [WIDTH-1:0] reload_val,
  output logic [WIDTH-1:0] shreg,
  output logic             full
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (armed) begin
      if (shift_pulse) begin
        shreg <= {shreg[WIDTH-2:0], din};
        if (bit_cnt != CW'(WIDTH)) bit_cnt <= bit_cnt + 1'b1;
      end
    end else begin
      shreg   <= reload_val;
      bit_cnt <= '0;
    end
  end

  assign full = (bit_cnt == CW'(WIDTH));
endmodule

// File: rtl/dly_setting_reg.sv
module dly_setting_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_load,
  input  logic [WIDTH-1:0] par_val,
  input  logic             ser_load,
  input  logic [WIDTH-1:0] ser_val,
  output logic [WIDTH-1:0] setting,
  output logic             setting_upd
);
  logic [WIDTH-1:0] set_nxt;

  always_comb begin
    set_nxt = setting;
    if (par_load)      set_nxt = par_val;
    else if (ser_load) set_nxt = ser_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setting     <= '0;
      setting_upd <= 1'b0;
    end else begin
      setting     <= set_nxt;
      setting_upd <= (set_nxt != setting);
    end
  end
endmodule

// File: rtl/dly_setting_loader.sv
module dly_setting_loader
  import dly_setting_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_mode,
  input  logic             load_en,
  input  logic [WIDTH-1:0] par_data,
  input  logic             ser_clk,
  input  logic             ser_din,
  output logic             ser_dout,
  output logic [WIDTH-1:0] setting,
  output logic             setting_upd
);
  localparam int SW      = WIDTH + 4;
  localparam int DIN_B   = WIDTH;
  localparam int SCLK_B  = WIDTH + 1;
  localparam int LE_B    = WIDTH + 2;
  localparam int MODE_B  = WIDTH + 3;

  logic [SW-1:0]    sync_in;
  logic [SW-1:0]    sync_out;
  logic             mode_s;
  logic             le_s;
  logic             sclk_s;
  logic             din_s;
  logic [WIDTH-1:0] par_s;
  logic             sclk_prev;
  logic             le_prev;
  logic             armed;
  logic             sclk_rise;
  logic             le_fall;
  logic             par_load;
  logic             ser_load;
  logic             ser_full;
  logic [WIDTH-1:0] shreg;

  assign sync_in = {ser_mode, load_en, ser_clk, ser_din, par_data};

  dly_input_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (sync_in),
    .d_out (sync_out)
  );

  assign mode_s = sync_out[MODE_B];
  assign le_s   = sync_out[LE_B];
  assign sclk_s = sync_out[SCLK_B];
  assign din_s  = sync_out[DIN_B];
  assign par_s  = sync_out[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      le_prev   <= le_s;
    end
  end

  assign armed     = (mode_s == LOAD_SERIAL) && le_s;
  assign sclk_rise = sclk_s && !sclk_prev;
  assign le_fall   = le_prev && !le_s;
  assign par_load  = (mode_s == LOAD_PARALLEL) && le_s;
  assign ser_load  = (mode_s == LOAD_SERIAL) && le_fall && ser_full;

  dly_serial_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .armed       (armed),
    .shift_pulse (sclk_rise),
    .din         (din_s),
    .reload_val  (setting),
    .shreg       (shreg),
    .full        (ser_full)
  );

  dly_setting_reg #(.WIDTH(WIDTH)) u_set (
    .clk         (clk),
    .rst         (rst),
    .par_load    (par_load),
    .par_val     (par_s),
    .ser_load    (ser_load),
    .ser_val     (shreg),
    .setting     (setting),
    .setting_upd (setting_upd)
  );

  assign ser_dout = shreg[WIDTH-1];
endmodule

// File: rtl/dly_setting_chk.sv
module dly_setting_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_s,
  input logic             le_s,
  input logic             sclk_s,
  input logic             sclk_prev,
  input logic             din_s,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] setting,
  input logic             setting_upd,
  input logic             ser_dout
);
  AST_PAR_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && le_s) |=> (setting == $past(par_s)));                 // R2
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !le_s) |=> $stable(setting));                         // R3
  AST_SHIFT_IN_LSB: assert property (@(posedge clk) disable iff (rst)
    (mode_s && le_s && sclk_s && !sclk_prev) |=> (shreg[0] == $past(din_s))); // R4
  AST_ARMED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode_s && le_s) |=> $stable(setting));                           // R5
  AST_DOUT_NEXT_OLD: assert property (@(posedge clk) disable iff (rst)
    (mode_s && le_s && sclk_s && !sclk_prev) |=> (ser_dout == $past(shreg[WIDTH-2]))); // R6
  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(setting) |-> setting_upd);                               // R8
  AST_UPD_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
    setting_upd |-> !$stable(setting));                               // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (setting == '0 && !setting_upd && shreg == '0));          // R9
endmodule

bind dly_setting_loader dly_setting_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mode_s      (mode_s),
  .le_s        (le_s),
  .sclk_s      (sclk_s),
  .sclk_prev   (sclk_prev),
  .din_s       (din_s),
  .par_s       (par_s),
  .shreg       (shreg),
  .setting     (setting),
  .setting_upd (setting_upd),
  .ser_dout    (ser_dout)
);

// File: tb/dly_setting_loader_tb_top.sv
module dly_setting_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SYNC       = 2;
  localparam int SW         = W + 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_mode = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] par_data = '0;
  logic         ser_clk = 1'b0;
  logic         ser_din = 1'b0;
  logic         ser_dout;
  logic [W-1:0] setting;
  logic         setting_upd;

  int n_chk  = 0;
  int n_fail = 0;
  int upd_cnt = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_setting_loader #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .load_en(load_en),
    .par_data(par_data), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .setting(setting), .setting_upd(setting_upd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: inputs delayed through a queue, state in plain variables
  logic [SW-1:0] mq[$];
  logic [W-1:0]  m_set, m_sh, m_nset;
  logic          m_upd, m_sc_p, m_le_p;
  int            m_cnt;
  logic [SW-1:0] m_s;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      for (int i = 0; i < SYNC; i++) mq.push_back('0);
      m_set = '0; m_sh = '0; m_upd = 1'b0; m_sc_p = 1'b0; m_le_p = 1'b0; m_cnt = 0;
      model_on = 1'b1;
    end else begin
      m_s = mq[SYNC-1];
      m_nset = m_set;
      if (!m_s[W+3] && m_s[W+2]) m_nset = m_s[W-1:0];
      if (m_s[W+3] && m_le_p && !m_s[W+2] && m_cnt >= W) m_nset = m_sh;
      if (m_s[W+3] && m_s[W+2]) begin
        if (m_s[W+1] && !m_sc_p) begin
          m_sh = {m_sh[W-2:0], m_s[W]};
          m_cnt++;
        end
      end else begin
        m_sh = m_set;
        m_cnt = 0;
      end
      m_upd  = (m_nset != m_set);
      m_set  = m_nset;
      m_sc_p = m_s[W+1];
      m_le_p = m_s[W+2];
      mq.push_front({ser_mode, load_en, ser_clk, ser_din, par_data});
      void'(mq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("model setting R2 R5", 32'(setting), 32'(m_set));
      chk("model strobe R8", 32'(setting_upd), 32'(m_upd));
      chk("model ser_dout R6", 32'(ser_dout), 32'(m_sh[W-1]));
      if (setting_upd) upd_cnt++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_xfer(input logic [31:0] bits, input int n, input bit wb,
                          output logic [31:0] seen);
    seen = '0;
    load_en = 1'b1;
    step(3);
    for (int i = 0; i < n; i++) begin
      seen[n-1-i] = ser_dout;
      ser_din = wb ? ser_dout : bits[n-1-i];
      step(1);
      ser_clk = 1'b1;
      step(3);
      ser_clk = 1'b0;
      step(3);
    end
    load_en = 1'b0;
    step(4);
  endtask

  initial begin
    logic [31:0] seen;
    int u0;
    step(4);
    chk("R9 reset setting", 32'(setting), 0);
    chk("R9 reset strobe", 32'(setting_upd), 0);
    chk("R9 reset ser_dout", 32'(ser_dout), 0);
    rst = 1'b0;
    step(2);

    // parallel transparent, exact latency
    load_en = 1'b1; par_data = 8'h5A;
    step(2);
    chk("R2 not yet at cycle 2", 32'(setting), 0);
    step(1);
    chk("R2 setting at cycle 3", 32'(setting), 32'h5A);
    chk("R8 strobe with change", 32'(setting_upd), 1);
    step(1);
    chk("R8 strobe one cycle", 32'(setting_upd), 0);

    // same value reloaded: no strobe
    u0 = upd_cnt;
    par_data = 8'h5A; step(5);
    chk("R8 no strobe on same value", 32'(upd_cnt - u0), 0);

    // parallel hold
    load_en = 1'b0; step(1);
    par_data = 8'h33; step(6);
    chk("R3 hold while latch closed", 32'(setting), 32'h5A);

    // serial mode ignores parallel inputs
    ser_mode = 1'b1; step(1);
    par_data = 8'hE7; step(6);
    chk("R1 par_data ignored in serial", 32'(setting), 32'h5A);

    // serial clocks while not armed
    for (int k = 0; k < 3; k++) begin
      ser_din = 1'b1; ser_clk = 1'b1; step(3); ser_clk = 1'b0; step(3);
    end
    chk("R4 unarmed clocks ignored setting", 32'(setting), 32'h5A);
    chk("R4 unarmed clocks ignored dout", 32'(ser_dout), 0);

    // full write, old value observed on ser_dout
    ser_xfer(32'hC3, 8, 1'b0, seen);
    chk("R6 old value shifted out", seen, 32'h5A);
    chk("R5 serial write applied", 32'(setting), 32'hC3);

    // short write: not applied
    ser_xfer(32'h1F, 5, 1'b0, seen);
    chk("R5 short write ignored", 32'(setting), 32'hC3);
    chk("R6 dout restored after short write", 32'(ser_dout), 1);

    // non-destructive read with write-back
    u0 = upd_cnt;
    ser_xfer(32'h0, 8, 1'b1, seen);
    chk("R6 readback value", seen, 32'hC3);
    chk("R6 readback keeps setting", 32'(setting), 32'hC3);
    chk("R8 no strobe after readback", 32'(upd_cnt - u0), 0);

    // chained transfer of 16 bits
    ser_xfer(32'h963C, 16, 1'b0, seen);
    chk("R7 last byte kept", 32'(setting), 32'h3C);
    chk("R7 first byte passed on", 32'(seen[7:0]), 32'h96);
    chk("R7 old value led the chain", 32'(seen[15:8]), 32'hC3);

    // reset with latch tied high in parallel mode
    rst = 1'b1; ser_mode = 1'b0; load_en = 1'b1; par_data = 8'hA5;
    step(3);
    chk("R9 reset clears setting", 32'(setting), 0);
    rst = 1'b0;
    step(3);
    chk("R2 follows inputs after reset", 32'(setting), 32'hA5);
    par_data = 8'h01; step(3);
    chk("R2 follows later change", 32'(setting), 32'h01);

    step(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule